// File: doc/BRIEF.md
# Write-Protected Serial Memory Command Engine

This block is the byte-level command engine of a 256-byte serial memory that sits behind a two-wire slave port. A bit-level front end, which is not part of this block, turns the wire activity into single-cycle events: a start, a stop, a received byte, and the master's acknowledge or no-acknowledge after each byte the slave sends. In return the engine gives an acknowledge decision for every received byte, and the next byte to transmit during reads.

The engine recognises its own device address. It runs byte writes, current-address reads, random reads (a dummy write that only loads the address, then a repeated start) and sequential reads. It keeps an address counter that wraps at the end of the memory. A separate frame type, recognised by a second fixed address code, sets or clears software write protection on the lower half of the memory. Protection comes in two kinds: a permanent kind that can never be undone, and a reversible kind that a clear command removes. Every completed write frame starts an internal write cycle. For the length of that cycle the device address is refused, so the host can poll for completion.

Top module: `wp_serial_mem`

## Requirements
- R1: A device address byte is accepted for memory access only when bits [7:4] equal 1010 and bits [3:1] equal `hwSel`. Bit 0 set means read and bit 0 clear means write. Any other address byte is answered with ackBit 0, and the rest of that frame is answered with ackBit 0.
- R2: In a write frame the device address, the byte address and one data byte are each acknowledged. The data byte is stored at the byte address when the stop arrives. Any further byte in the same frame gets ackBit 0, and the first data byte is still stored.
- R3: A stop that ends a complete write frame (a memory write or a protection command) raises `busy` in the next cycle, for exactly WRITE_CYCLES cycles. Any device address byte received while `busy` is high gets ackBit 0.
- R4: After a write, the address counter holds the written address plus one. After each transmitted byte it holds that byte's address plus one. A current-address read returns the byte at the counter.
- R5: A write frame stopped right after the byte address loads the counter and starts no write cycle. A repeated start followed by a read address then returns the byte at that address.
- R6: In a read, each master acknowledge produces the next byte in the following cycle. A master no-acknowledge ends the read and produces no byte. Address FFh is followed by 00h.
- R7: While any protection is set, a write to 00h–7Fh is acknowledged but leaves the memory unchanged. Writes to 80h–FFh are always stored.
- R8: A protection frame is a write frame whose address byte has bits [7:4] = 0110 and bit 0 = 0, with the command in bits [3:1]: 001 sets reversible protection, 011 clears it, 000 sets permanent protection. It carries two don't-care bytes and takes effect at the stop.
- R9: Permanent protection is never cleared. Once it is set, a set-permanent or clear-reversible address byte gets ackBit 0, while set-reversible is still accepted.
- R10: `ackValid` pulses in the cycle after each received byte of an active frame. `txValid` with `txData` pulses in the cycle after an accepted read address or a master acknowledge.
- R11: After reset the memory holds zeros, the counter is 00h, no protection is set and `busy`, `ackValid` and `txValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwSel | input | 3 | Hardware-strapped device select bits |
| busStart | input | 1 | Start or repeated start event |
| busStop | input | 1 | Stop event |
| rxValid | input | 1 | A byte was received from the master |
| rxByte | input | 8 | Received byte |
| mAckValid | input | 1 | Master acknowledge slot after a transmitted byte |
| mAckNack | input | 1 | 1 when the master did not acknowledge |
| ackValid | output | 1 | Acknowledge decision is valid |
| ackBit | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| txValid | output | 1 | Next byte to transmit is valid |
| txData | output | 8 | Byte to transmit |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bench drives a sequential read across address FFh. A counter that saturates, or that fails to wrap, returns the wrong third byte. It polls the device during the write cycle and counts the cycle's length, which exposes a design that acknowledges while busy or times the cycle off by one. It checks that a write to a protected low address is still acknowledged and leaves the memory unchanged, while a high address is still written. It also sends clear and repeated-set commands after permanent protection is set: a design that lets either one through would either drop the protection or acknowledge a frame it must refuse.

// File: rtl/wpsm_pkg.sv
package wpsm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_WSTOP,
    ST_PADDR,
    ST_PDATA,
    ST_PSTOP,
    ST_READ,
    ST_IGNORE
  } ctrl_state_e;

  typedef enum logic [1:0] {
    PC_SET_PERM,
    PC_SET_REV,
    PC_CLR_REV,
    PC_NONE
  } prot_cmd_e;

  // Strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic      loadAddr;
    logic      latchData;
    logic      commitWrite;
    logic      readNext;
    logic      applyProt;
    prot_cmd_e protCmd;
  } dp_strobe_t;

  // Command select field of a protection frame, bits [3:1]
  localparam logic [2:0] SEL_SET_PERM = 3'b000;
  localparam logic [2:0] SEL_SET_REV  = 3'b001;
  localparam logic [2:0] SEL_CLR_REV  = 3'b011;

endpackage

// File: rtl/wpsm_ctrl.sv
module wpsm_ctrl
  import wpsm_pkg::*;
#(
  parameter logic [3:0] MEM_CODE  = 4'b1010,
  parameter logic [3:0] PROT_CODE = 4'b0110
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hwSel,
  input  logic       busStart,
  input  logic       busStop,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       mAckValid,
  input  logic       mAckNack,
  input  logic       busy,
  input  logic       permSet,
  output logic       ackValid,
  output logic       ackBit,
  output dp_strobe_t stb
);

  ctrl_state_e state, nextState;
  prot_cmd_e   pendCmd, nextCmd;
  logic        ackValidNext, ackBitNext;

  logic      memHit, protHit, cmdOk;
  prot_cmd_e selCmd;

  always_comb begin
    memHit  = (rxByte[7:4] == MEM_CODE) && (rxByte[3:1] == hwSel);
    protHit = (rxByte[7:4] == PROT_CODE) && !rxByte[0];
    unique case (rxByte[3:1])
      SEL_SET_PERM: selCmd = PC_SET_PERM;
      SEL_SET_REV:  selCmd = PC_SET_REV;
      SEL_CLR_REV:  selCmd = PC_CLR_REV;
      default:      selCmd = PC_NONE;
    endcase
    unique case (selCmd)
      PC_SET_PERM: cmdOk = !permSet;
      PC_SET_REV:  cmdOk = 1'b1;
      PC_CLR_REV:  cmdOk = !permSet;
      default:     cmdOk = 1'b0;
    endcase
  end

  always_comb begin
    nextState    = state;
    nextCmd      = pendCmd;
    stb          = '0;
    stb.protCmd  = pendCmd;
    ackValidNext = 1'b0;
    ackBitNext   = 1'b0;
    if (busStart) begin
      nextState = ST_DEV;
    end else if (busStop) begin
      nextState = ST_IDLE;
      if (state == ST_WSTOP) stb.commitWrite = 1'b1;
      if (state == ST_PSTOP) stb.applyProt   = 1'b1;
    end else if (rxValid && state != ST_IDLE) begin
      ackValidNext = 1'b1;
      unique case (state)
        ST_DEV: begin
          if (busy) begin
            nextState = ST_IGNORE;
          end else if (memHit) begin
            ackBitNext = 1'b1;
            if (rxByte[0]) begin
              nextState    = ST_READ;
              stb.readNext = 1'b1;
            end else begin
              nextState = ST_WADDR;
            end
          end else if (protHit && cmdOk) begin
            ackBitNext = 1'b1;
            nextCmd    = selCmd;
            nextState  = ST_PADDR;
          end else begin
            nextState = ST_IGNORE;
          end
        end
        ST_WADDR: begin
          ackBitNext   = 1'b1;
          stb.loadAddr = 1'b1;
          nextState    = ST_WDATA;
        end
        ST_WDATA: begin
          ackBitNext    = 1'b1;
          stb.latchData = 1'b1;
          nextState     = ST_WSTOP;
        end
        ST_PADDR: begin
          ackBitNext = 1'b1;
          nextState  = ST_PDATA;
        end
        ST_PDATA: begin
          ackBitNext = 1'b1;
          nextState  = ST_PSTOP;
        end
        default: ackBitNext = 1'b0;
      endcase
    end else if (mAckValid && state == ST_READ) begin
      if (mAckNack) nextState = ST_IGNORE;
      else          stb.readNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendCmd  <= PC_NONE;
      ackValid <= 1'b0;
      ackBit   <= 1'b0;
    end else begin
      state    <= nextState;
      pendCmd  <= nextCmd;
      ackValid <= ackValidNext;
      ackBit   <= ackBitNext;
    end
  end

endmodule

// File: rtl/wpsm_datapath.sv
module wpsm_datapath
  import wpsm_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        stb,
  input  logic [7:0]        rxByte,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic              busy,
  output logic              permSet
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrCnt, wrAddr;
  logic [DATA_W-1:0] wrData;
  logic              permFlag, revFlag;
  logic [BUSY_W-1:0] busyCnt;
  logic              writeAllowed;

  // Lower half is guarded by either protection kind
  assign writeAllowed = wrAddr[ADDR_W-1] || !(permFlag || revFlag);
  assign busy         = (busyCnt != '0);
  assign permSet      = permFlag;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[i] <= '0;
      end else if (stb.commitWrite && writeAllowed && wrAddr == ADDR_W'(i)) begin
        mem[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt <= '0;
      wrAddr  <= '0;
      wrData  <= '0;
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= stb.readNext;
      if (stb.loadAddr) begin
        wrAddr  <= rxByte[ADDR_W-1:0];
        addrCnt <= rxByte[ADDR_W-1:0];
      end else if (stb.commitWrite) begin
        addrCnt <= wrAddr + ADDR_W'(1);
      end else if (stb.readNext) begin
        txData  <= mem[addrCnt];
        addrCnt <= addrCnt + ADDR_W'(1);
      end
      if (stb.latchData) wrData <= rxByte[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      permFlag <= 1'b0;
      revFlag  <= 1'b0;
      busyCnt  <= '0;
    end else begin
      if (stb.commitWrite || stb.applyProt) busyCnt <= BUSY_W'(WRITE_CYCLES);
      else if (busyCnt != '0)               busyCnt <= busyCnt - BUSY_W'(1);
      if (stb.applyProt) begin
        unique case (stb.protCmd)
          PC_SET_PERM: permFlag <= 1'b1;
          PC_SET_REV:  revFlag  <= 1'b1;
          PC_CLR_REV:  revFlag  <= 1'b0;
          default:     revFlag  <= revFlag;
        endcase
      end
    end
  end

endmodule

// File: rtl/wp_serial_mem.sv
module wp_serial_mem
  import wpsm_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter int         WRITE_CYCLES = 40,
  parameter logic [3:0] MEM_CODE     = 4'b1010,
  parameter logic [3:0] PROT_CODE    = 4'b0110
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hwSel,
  input  logic       busStart,
  input  logic       busStop,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       mAckValid,
  input  logic       mAckNack,
  output logic       ackValid,
  output logic       ackBit,
  output logic       txValid,
  output logic [7:0] txData,
  output logic       busy
);

  dp_strobe_t stb;
  logic       permSet;

  wpsm_ctrl #(
    .MEM_CODE (MEM_CODE),
    .PROT_CODE(PROT_CODE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hwSel    (hwSel),
    .busStart (busStart),
    .busStop  (busStop),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .mAckValid(mAckValid),
    .mAckNack (mAckNack),
    .busy     (busy),
    .permSet  (permSet),
    .ackValid (ackValid),
    .ackBit   (ackBit),
    .stb      (stb)
  );

  wpsm_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (8),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rxByte (rxByte),
    .txValid(txValid),
    .txData (txData),
    .busy   (busy),
    .permSet(permSet)
  );

endmodule

// File: rtl/wp_serial_mem_chk.sv
module wp_serial_mem_chk #(
  parameter int WRITE_CYCLES = 40
) (
  input logic clk,
  input logic rstN,
  input logic busStop,
  input logic rxValid,
  input logic mAckValid,
  input logic ackValid,
  input logic txValid,
  input logic busy,
  input logic permSet
);

  localparam int RUN_W = $clog2(WRITE_CYCLES + 2);

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + RUN_W'(1);
    else           busyRun <= '0;
  end

  // R10: an acknowledge decision only follows a received byte
  assert_ack_after_byte_R10: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(rxValid));

  // R10: a transmit byte only follows a read address or a master acknowledge
  assert_tx_after_event_R10: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> ($past(rxValid) || $past(mAckValid)));

  // R3: the write cycle begins only after a stop
  assert_busy_after_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busStop));

  // R3: the write cycle never outlasts its length
  assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < RUN_W'(WRITE_CYCLES)));

  // R9: permanent protection stays set
  assert_perm_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    permSet |=> permSet);

endmodule

bind wp_serial_mem wp_serial_mem_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busStop  (busStop),
  .rxValid  (rxValid),
  .mAckValid(mAckValid),
  .ackValid (ackValid),
  .txValid  (txValid),
  .busy     (busy),
  .permSet  (permSet)
);

// File: tb/wp_serial_mem_tb.sv
module wp_serial_mem_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 40;
  localparam logic [2:0] HW = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, HW, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, HW, 1'b1};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busStart = 1'b0, busStop = 1'b0, rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       mAckValid = 1'b0, mAckNack = 1'b0;
  logic       ackValid, ackBit, txValid, busy;
  logic [7:0] txData;

  int checkCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wp_serial_mem #(.WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rstN(rstN), .hwSel(HW),
    .busStart(busStart), .busStop(busStop),
    .rxValid(rxValid), .rxByte(rxByte),
    .mAckValid(mAckValid), .mAckNack(mAckNack),
    .ackValid(ackValid), .ackBit(ackBit),
    .txValid(txValid), .txData(txData), .busy(busy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  task automatic doStart;
    @(negedge clk) busStart = 1'b1;
    @(negedge clk) busStart = 1'b0;
  endtask

  task automatic doStop;
    @(negedge clk) busStop = 1'b1;
    @(negedge clk) busStop = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    @(negedge clk) begin rxValid = 1'b1; rxByte = b; end
    @(negedge clk) rxValid = 1'b0;
    acked = ackValid && ackBit;
  endtask

  task automatic masterAck(input logic nack, output logic v, output logic [7:0] d);
    @(negedge clk) begin mAckValid = 1'b1; mAckNack = nack; end
    @(negedge clk) mAckValid = 1'b0;
    v = txValid;
    d = txData;
  endtask

  task automatic waitIdle;
    while (busy) @(negedge clk);
  endtask

  task automatic memWrite(input logic [7:0] a, input logic [7:0] d, output logic allAck);
    logic a0, a1, a2;
    doStart;
    sendByte(DEV_W, a0);
    sendByte(a, a1);
    sendByte(d, a2);
    doStop;
    waitIdle;
    allAck = a0 && a1 && a2;
  endtask

  task automatic randRead(input logic [7:0] a, output logic [7:0] d);
    logic ak, v;
    logic [7:0] dd;
    doStart;
    sendByte(DEV_W, ak);
    sendByte(a, ak);
    doStart;
    sendByte(DEV_R, ak);
    d = txData;
    masterAck(1'b1, v, dd);
    doStop;
  endtask

  task automatic protFrame(input logic [2:0] sel, output logic acked);
    logic ak;
    doStart;
    sendByte({4'b0110, sel, 1'b0}, acked);
    if (acked) begin
      sendByte(8'h00, ak);
      sendByte(8'h00, ak);
    end
    doStop;
    waitIdle;
  endtask

  task automatic t_reset;
    logic ak, v;
    logic [7:0] d;
    check("R11", "busy after reset", busy, 0);
    check("R11", "ackValid after reset", ackValid, 0);
    check("R11", "txValid after reset", txValid, 0);
    doStart;
    sendByte(DEV_R, ak);
    check("R11", "read address ack", ak, 1);
    check("R11", "byte at counter 00h", txData, 8'h00);
    check("R10", "txValid with read ack", txValid, 1);
    masterAck(1'b1, v, d);
    check("R6", "no byte after nack", v, 0);
    doStop;
  endtask

  task automatic t_address;
    logic ak;
    doStart;
    sendByte({4'b1010, 3'b010, 1'b0}, ak);
    check("R1", "wrong select bits nacked", ak, 0);
    sendByte(8'h33, ak);
    check("R1", "rest of foreign frame nacked", ak, 0);
    doStop;
    doStart;
    sendByte({4'b1011, HW, 1'b0}, ak);
    check("R1", "wrong fixed code nacked", ak, 0);
    doStop;
    doStart;
    sendByte(DEV_W, ak);
    check("R1", "own write address acked", ak, 1);
    doStop;
  endtask

  task automatic t_write_busy;
    logic ak, a1, a2, a3, a4;
    logic [7:0] d;
    int n;
    // cycle length
    doStart;
    sendByte(DEV_W, a1);
    sendByte(8'h10, a2);
    sendByte(8'hA5, a3);
    doStop;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check("R2", "write frame acks", {a1, a2, a3}, 3'b111);
    check("R3", "write cycle length", n, WCYC);
    // poll during busy, and extra data byte
    doStart;
    sendByte(DEV_W, a1);
    sendByte(8'h11, a2);
    sendByte(8'h5A, a3);
    sendByte(8'hEE, a4);
    check("R2", "extra data byte nacked", a4, 0);
    doStop;
    doStart;
    sendByte(DEV_R, ak);
    check("R3", "address nacked while busy", ak, 0);
    doStop;
    waitIdle;
    randRead(8'h10, d);
    check("R5", "random read 10h", d, 8'hA5);
    doStart;
    sendByte(DEV_R, ak);
    check("R4", "current read after read of 10h", txData, 8'h5A);
    masterAck(1'b1, ak, d);
    doStop;
    memWrite(8'h21, 8'hC3, ak);
    memWrite(8'h20, 8'h3C, ak);
    doStart;
    sendByte(DEV_R, ak);
    check("R4", "current read after write of 20h", txData, 8'hC3);
    masterAck(1'b1, ak, d);
    doStop;
    // dummy write starts no cycle
    doStart;
    sendByte(DEV_W, ak);
    sendByte(8'h20, ak);
    doStop;
    check("R5", "no busy after address-only frame", busy, 0);
  endtask

  task automatic t_seq_wrap;
    logic ak, v;
    logic [7:0] d;
    memWrite(8'hFE, 8'h11, ak);
    memWrite(8'hFF, 8'h22, ak);
    memWrite(8'h00, 8'h33, ak);
    doStart;
    sendByte(DEV_W, ak);
    sendByte(8'hFE, ak);
    doStart;
    sendByte(DEV_R, ak);
    check("R6", "first byte FEh", txData, 8'h11);
    masterAck(1'b0, v, d);
    check("R6", "byte FFh", d, 8'h22);
    masterAck(1'b0, v, d);
    check("R6", "wrap to 00h", d, 8'h33);
    check("R10", "txValid after master ack", v, 1);
    masterAck(1'b1, v, d);
    check("R6", "nack ends read", v, 0);
    doStop;
  endtask

  task automatic t_reversible;
    logic ak;
    logic [7:0] d;
    protFrame(3'b001, ak);
    check("R8", "set reversible acked", ak, 1);
    memWrite(8'h05, 8'h77, ak);
    check("R7", "protected write acked", ak, 1);
    randRead(8'h05, d);
    check("R7", "protected byte unchanged", d, 8'h00);
    memWrite(8'h85, 8'h66, ak);
    randRead(8'h85, d);
    check("R7", "upper half written", d, 8'h66);
    protFrame(3'b011, ak);
    check("R8", "clear reversible acked", ak, 1);
    memWrite(8'h05, 8'h77, ak);
    randRead(8'h05, d);
    check("R8", "write after clear stored", d, 8'h77);
  endtask

  task automatic t_permanent;
    logic ak;
    logic [7:0] d;
    protFrame(3'b000, ak);
    check("R9", "set permanent acked", ak, 1);
    memWrite(8'h06, 8'h44, ak);
    randRead(8'h06, d);
    check("R7", "permanent blocks low write", d, 8'h00);
    protFrame(3'b011, ak);
    check("R9", "clear nacked when permanent", ak, 0);
    protFrame(3'b000, ak);
    check("R9", "second permanent nacked", ak, 0);
    protFrame(3'b001, ak);
    check("R9", "set reversible still acked", ak, 1);
    memWrite(8'h05, 8'h11, ak);
    randRead(8'h05, d);
    check("R9", "low byte still protected", d, 8'h77);
    memWrite(8'h90, 8'h99, ak);
    randRead(8'h90, d);
    check("R7", "upper half written under permanent", d, 8'h99);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_address;
    t_write_busy;
    t_seq_wrap;
    t_reversible;
    t_permanent;
    finishRun;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun;
  end

endmodule